// File: doc/BRIEF.md
# Floating-Point Status and Control Register Unit

This block holds the 32-bit status and control word of a floating-point pipeline. Bits are named MSB-0, so bit n of the architected view sits at LSB position 31-n. The word carries sticky exception flags, exception enables, the result-class field, rounding control and three summary bits that the block computes itself. A single-cycle strobe `cmd_valid_i` applies one command. The commands are: set one bit, clear one bit, load a 4-bit field from an immediate, write under a byte-wide field mask from a 32-bit operand, copy a field out to a condition-register field, and merge an exception report from the arithmetic unit.

A merge folds the reported vector into the word. It keeps the changed-exception, enabled-exception and invalid-summary bits consistent with the architected rules, and it replaces the result-class field when a new class arrives. It can also forward condition bits for a record-form operation or a compare. All outputs are registered. `trap_o` asks the core to take a floating-point exception after any command that leaves the enabled-exception bit set.

Top module: `fsr_unit`

## Requirements
- R1: After a synchronous active-high reset, `fsr_o` is 0 and `trap_o` and `cr_valid_o` are 0.
- R2: Opcode 0 (set) drives LSB position 31-n of the word to 1, and opcode 1 (clear) drives it to 0, where n is `bit_idx_i`. All other bits are unchanged.
- R3: Set and clear aimed at n=1 (enabled-exception bit, LSB 30) or n=2 (invalid summary, LSB 29) leave the whole word unchanged.
- R4: Opcode 2 writes `imm_i` into field k=`fld_idx_i`, which occupies LSB bits 31-4k down to 28-4k. The other fields are unchanged.
- R5: Opcode 3 maps each `fmask_i` bit i to LSB bits 4i+3..4i and loads those bits from `wdata_i`. An all-ones mask replaces the whole word, and a zero mask changes nothing.
- R6: Opcode 5 (merge) with a non-zero `exc_i` first clears the changed-exception bit (LSB 31). It then sets that bit if the vector reports a sticky exception that was clear before. The sticky exceptions are LSB 31, 28..19 and 10..8. A zero vector leaves the word unchanged.
- R7: A merge sets the enabled-exception bit (LSB 30) when a reported exception among LSB 29..25 meets its enable 22 positions lower (LSB 7..3). The derived invalid summary counts as reported. The bit stays set until a write or move command changes it.
- R8: A merge that reports any invalid sub-cause (LSB 24..19 or 10..8) sets the invalid summary bit (LSB 29).
- R9: A merge whose vector has any result-class bit (LSB 16..12) clears the old result-class field before the reported bits are ORed in.
- R10: One cycle after a merge, `cr_valid_o` pulses. With `cmp_i`, `cr_field_o` carries LSB 15..12 of the new word and `cr_idx_o`=`crf_idx_i`. Otherwise, with `rec_i`, it carries LSB 31..28 and `cr_idx_o`=1. `cmp_i` takes priority over `rec_i`.
- R11: `trap_o` is 1 for the cycle after any command whose resulting word has LSB 30 set, and 0 otherwise.
- R12: Opcode 4 outputs field `fld_idx_i` of the old word on `cr_field_o` at index `crf_idx_i`. It clears the sticky exception bits inside that field and leaves every other bit unchanged.
- R13: Each command takes effect at the clock edge where it is strobed. With no strobe, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 3 | Command code (0 set, 1 clear, 2 field immediate, 3 masked write, 4 field to CR, 5 merge) |
| bit_idx_i | input | 5 | MSB-0 bit number for set/clear |
| fld_idx_i | input | 3 | Field index for immediate write and field move |
| crf_idx_i | input | 3 | Target condition field for compare and field move |
| imm_i | input | 4 | Immediate nibble |
| fmask_i | input | 8 | Field mask for masked write |
| wdata_i | input | 32 | Operand for masked write |
| exc_i | input | 32 | Exception and class report for merge |
| rec_i | input | 1 | Merge is record-form |
| cmp_i | input | 1 | Merge is a compare |
| fsr_o | output | 32 | Status and control word |
| trap_o | output | 1 | Trap request |
| cr_valid_o | output | 1 | Condition field output valid |
| cr_field_o | output | 4 | Condition field value |
| cr_idx_o | output | 3 | Condition field index |

## Verification
The bench reports the same overflow twice. A design that compared against the whole old word, rather than against bits newly set, would leave the changed-exception bit raised on the repeat. It raises an invalid sub-cause with its enable set, so a design that checked enables before deriving the invalid summary would miss the trap. It replaces a full result-class field with a single class bit, which exposes an OR-only merge. It moves a field that holds both sticky and summary bits. A design that cleared the whole field, or took the moved value after clearing, would show the wrong word or the wrong nibble. Summary bits aimed by set/clear must not move, and a zero field mask must not write.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    OP_SETB  = 3'd0,
    OP_CLRB  = 3'd1,
    OP_FIMM  = 3'd2,
    OP_MWR   = 3'd3,
    OP_TOCR  = 3'd4,
    OP_MERGE = 3'd5
  } fsr_op_e;

  // LSB positions of the computed summary bits
  localparam int B_CHG = 31;
  localparam int B_ENX = 30;
  localparam int B_INV = 29;

  // distance between an exception bit and its enable
  localparam int EN_GAP = 22;
  // condition-code nibble low bit
  localparam int CC_LO  = 12;
  // condition field that receives record-form status
  localparam logic [2:0] REC_FIELD = 3'd1;

  localparam logic [31:0] STICKY_M = 32'h9FF8_0700;
  localparam logic [31:0] INVSUB_M = 32'h01F8_0700;
  localparam logic [31:0] ENABLE_M = 32'h0000_00F8;
  localparam logic [31:0] CLASS_M  = 32'h0001_F000;
endpackage

// File: rtl/fsr_nib_mask.sv
module fsr_nib_mask #(
  parameter int FIELDS = 8,
  parameter int NIB    = 4,
  localparam int W     = FIELDS * NIB
) (
  input  logic [FIELDS-1:0] fmask_i,
  output logic [W-1:0]      mask_o
);
  for (genvar i = 0; i < FIELDS; i++) begin : g_nib
    assign mask_o[NIB*i +: NIB] = {NIB{fmask_i[i]}};
  end

  always_comb begin
    assert ($countones(mask_o) == NIB * $countones(fmask_i))
      else $error("assert_nib_expand_R5: nibble mask width mismatch");
  end
endmodule

// File: rtl/fsr_exc_merge.sv
module fsr_exc_merge
  import fsr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] exc_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] eff;
  logic [W-1:0] en_up;
  logic         new_sticky;
  logic         hit_en;

  always_comb begin
    eff = exc_i;
    if (|(exc_i & INVSUB_M)) eff[B_INV] = 1'b1;
    en_up      = (old_i & ENABLE_M) << EN_GAP;
    new_sticky = |(exc_i & STICKY_M & ~old_i);
    hit_en     = |(eff & en_up);
    nxt_o      = old_i;
    if (|exc_i) begin
      nxt_o[B_CHG] = new_sticky;
      if (hit_en) nxt_o[B_ENX] = 1'b1;
      if (|(exc_i & CLASS_M)) nxt_o = nxt_o & ~CLASS_M;
      nxt_o = nxt_o | eff;
    end
  end

  always_comb begin
    if (|(exc_i & INVSUB_M))
      assert (nxt_o[B_INV]) else $error("assert_inv_summary_R8: invalid summary not set");
    if (exc_i == '0)
      assert (nxt_o == old_i) else $error("assert_zero_report_R6: zero report changed word");
  end
endmodule

// File: rtl/fsr_cr_route.sv
module fsr_cr_route
  import fsr_pkg::*;
#(
  parameter int FIELDS = 8,
  parameter int NIB    = 4,
  localparam int W     = FIELDS * NIB,
  localparam int FIW   = $clog2(FIELDS)
) (
  input  fsr_op_e          op_i,
  input  logic [W-1:0]     old_i,
  input  logic [W-1:0]     new_i,
  input  logic [FIW-1:0]   fld_idx_i,
  input  logic [FIW-1:0]   crf_idx_i,
  input  logic             rec_i,
  input  logic             cmp_i,
  output logic             valid_o,
  output logic [NIB-1:0]   field_o,
  output logic [FIW-1:0]   idx_o
);
  always_comb begin
    valid_o = 1'b0;
    field_o = '0;
    idx_o   = '0;
    if (op_i == OP_TOCR) begin
      valid_o = 1'b1;
      field_o = old_i[W-1-NIB*int'(fld_idx_i) -: NIB];
      idx_o   = crf_idx_i;
    end else if (op_i == OP_MERGE && cmp_i) begin
      valid_o = 1'b1;
      field_o = new_i[CC_LO +: NIB];
      idx_o   = crf_idx_i;
    end else if (op_i == OP_MERGE && rec_i) begin
      valid_o = 1'b1;
      field_o = new_i[W-1 -: NIB];
      idx_o   = REC_FIELD;
    end
  end
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
#(
  parameter int FIELDS = 8,
  parameter int NIB    = 4,
  localparam int W     = FIELDS * NIB,
  localparam int FIW   = $clog2(FIELDS),
  localparam int BIW   = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [BIW-1:0]    bit_idx_i,
  input  logic [FIW-1:0]    fld_idx_i,
  input  logic [FIW-1:0]    crf_idx_i,
  input  logic [NIB-1:0]    imm_i,
  input  logic [FIELDS-1:0] fmask_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      exc_i,
  input  logic              rec_i,
  input  logic              cmp_i,
  output logic [W-1:0]      fsr_o,
  output logic              trap_o,
  output logic              cr_valid_o,
  output logic [NIB-1:0]    cr_field_o,
  output logic [FIW-1:0]    cr_idx_o
);
  fsr_op_e         op;
  logic [W-1:0]    fsr_q, fsr_d;
  logic [W-1:0]    wr_mask, imm_mask, merged;
  logic [FIELDS-1:0] imm_sel;
  logic [W-1:0]    bit_sel;
  logic            cr_v;
  logic [NIB-1:0]  cr_f;
  logic [FIW-1:0]  cr_i;

  assign op      = fsr_op_e'(cmd_op_i);
  assign imm_sel = FIELDS'(1) << (FIELDS - 1 - int'(fld_idx_i));
  assign bit_sel = W'(1) << (W - 1 - int'(bit_idx_i));

  fsr_nib_mask #(.FIELDS(FIELDS), .NIB(NIB)) u_wr_mask (
    .fmask_i(fmask_i), .mask_o(wr_mask));
  fsr_nib_mask #(.FIELDS(FIELDS), .NIB(NIB)) u_imm_mask (
    .fmask_i(imm_sel), .mask_o(imm_mask));

  fsr_exc_merge #(.W(W)) u_merge (
    .old_i(fsr_q), .exc_i(exc_i), .nxt_o(merged));

  fsr_cr_route #(.FIELDS(FIELDS), .NIB(NIB)) u_route (
    .op_i(op), .old_i(fsr_q), .new_i(merged), .fld_idx_i(fld_idx_i),
    .crf_idx_i(crf_idx_i), .rec_i(rec_i), .cmp_i(cmp_i),
    .valid_o(cr_v), .field_o(cr_f), .idx_o(cr_i));

  logic summary_hit;
  assign summary_hit = bit_sel[B_ENX] | bit_sel[B_INV];

  always_comb begin
    fsr_d = fsr_q;
    unique case (op)
      OP_SETB:  if (!summary_hit) fsr_d = fsr_q | bit_sel;
      OP_CLRB:  if (!summary_hit) fsr_d = fsr_q & ~bit_sel;
      OP_FIMM:  fsr_d = (fsr_q & ~imm_mask) | ({FIELDS{imm_i}} & imm_mask);
      OP_MWR:   fsr_d = (fsr_q & ~wr_mask) | (wdata_i & wr_mask);
      OP_TOCR:  fsr_d = fsr_q & ~(imm_mask & STICKY_M);
      OP_MERGE: fsr_d = merged;
      default:  fsr_d = fsr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q      <= '0;
      trap_o     <= 1'b0;
      cr_valid_o <= 1'b0;
      cr_field_o <= '0;
      cr_idx_o   <= '0;
    end else begin
      trap_o     <= 1'b0;
      cr_valid_o <= 1'b0;
      if (cmd_valid_i) begin
        fsr_q      <= fsr_d;
        trap_o     <= fsr_d[B_ENX];
        cr_valid_o <= cr_v;
        if (cr_v) begin
          cr_field_o <= cr_f;
          cr_idx_o   <= cr_i;
        end
      end
    end
  end

  assign fsr_o = fsr_q;

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_i |=> $stable(fsr_o));
  assert_trap_flag_R11: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> fsr_o[B_ENX]);
  assert_clear_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i == 3'd1 && bit_idx_i > 2)
      |=> (fsr_o & (32'h8000_0000 >> $past(bit_idx_i))) == '0);
  assert_summary_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_op_i <= 3'd1 && (bit_idx_i == 1 || bit_idx_i == 2))
      |=> $stable(fsr_o));
  assert_cr_source_R10: assert property (@(posedge clk) disable iff (rst)
    cr_valid_o |-> $past(cmd_valid_i));
endmodule

// File: tb/fsr_unit_tb.sv
`timescale 1ns/1ps
module fsr_unit_tb_top;
  import fsr_pkg::*;

  logic        clk = 0;
  logic        rst = 1;
  logic        cmd_valid_i = 0;
  logic [2:0]  cmd_op_i = 0;
  logic [4:0]  bit_idx_i = 0;
  logic [2:0]  fld_idx_i = 0, crf_idx_i = 0;
  logic [3:0]  imm_i = 0;
  logic [7:0]  fmask_i = 0;
  logic [31:0] wdata_i = 0, exc_i = 0;
  logic        rec_i = 0, cmp_i = 0;
  logic [31:0] fsr_o;
  logic        trap_o, cr_valid_o;
  logic [3:0]  cr_field_o;
  logic [2:0]  cr_idx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fsr_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input fsr_op_e op, input logic [4:0] bi, input logic [2:0] fi,
                     input logic [2:0] ci, input logic [3:0] im, input logic [7:0] fm,
                     input logic [31:0] wd, input logic [31:0] ex, input logic rc,
                     input logic cp);
    @(negedge clk);
    cmd_op_i = op; bit_idx_i = bi; fld_idx_i = fi; crf_idx_i = ci; imm_i = im;
    fmask_i = fm; wdata_i = wd; exc_i = ex; rec_i = rc; cmp_i = cp;
    cmd_valid_i = 1;
    @(negedge clk);
    cmd_valid_i = 0; exc_i = 0; rec_i = 0; cmp_i = 0; fmask_i = 0;
  endtask

  task automatic wipe();
    cmd(OP_MWR, 0, 0, 0, 0, 8'hFF, 32'h0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 word", fsr_o, 0);
    chk("R1 trap", 32'(trap_o), 0);
    chk("R1 crv", 32'(cr_valid_o), 0);
  endtask

  task automatic t_bits();
    cmd(OP_SETB, 3, 0, 0, 0, 0, 0, 0, 0, 0);  chk("R2 set n3", fsr_o, 32'h1000_0000);
    cmd(OP_CLRB, 3, 0, 0, 0, 0, 0, 0, 0, 0);  chk("R2 clr n3", fsr_o, 0);
    cmd(OP_SETB, 31, 0, 0, 0, 0, 0, 0, 0, 0); chk("R2 set n31", fsr_o, 32'h1);
    cmd(OP_CLRB, 31, 0, 0, 0, 0, 0, 0, 0, 0); chk("R2 clr n31", fsr_o, 0);
    cmd(OP_SETB, 1, 0, 0, 0, 0, 0, 0, 0, 0);  chk("R3 set n1", fsr_o, 0);
    cmd(OP_SETB, 2, 0, 0, 0, 0, 0, 0, 0, 0);  chk("R3 set n2", fsr_o, 0);
    chk("R11 no trap", 32'(trap_o), 0);
  endtask

  task automatic t_fimm();
    cmd(OP_FIMM, 0, 7, 0, 4'h3, 0, 0, 0, 0, 0); chk("R4 field7", fsr_o, 32'h0000_0003);
    cmd(OP_FIMM, 0, 0, 0, 4'hA, 0, 0, 0, 0, 0); chk("R4 field0", fsr_o, 32'hA000_0003);
    cmd(OP_FIMM, 0, 4, 0, 4'h5, 0, 0, 0, 0, 0); chk("R4 field4", fsr_o, 32'hA000_5003);
  endtask

  task automatic t_mwr();
    cmd(OP_MWR, 0, 0, 0, 0, 8'hFF, 32'h1234_5678, 0, 0, 0);
    chk("R5 all ones", fsr_o, 32'h1234_5678);
    cmd(OP_MWR, 0, 0, 0, 0, 8'h00, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R5 zero mask", fsr_o, 32'h1234_5678);
    cmd(OP_MWR, 0, 0, 0, 0, 8'h81, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R5 ends", fsr_o, 32'hF234_567F);
    chk("R11 trap after write", 32'(trap_o), 1);
  endtask

  task automatic t_merge_en();
    wipe();
    cmd(OP_SETB, 25, 0, 0, 0, 0, 0, 0, 0, 0);
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h1000_0000, 1, 0);
    chk("R7 first ovf", fsr_o, 32'hD000_0040);
    chk("R11 trap", 32'(trap_o), 1);
    chk("R10 rec valid", 32'(cr_valid_o), 1);
    chk("R10 rec field", 32'(cr_field_o), 32'hD);
    chk("R10 rec idx", 32'(cr_idx_o), 1);
    @(negedge clk);
    chk("R10 pulse", 32'(cr_valid_o), 0);
    chk("R11 trap pulse", 32'(trap_o), 0);
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h1000_0000, 0, 0);
    chk("R6 repeat ovf", fsr_o, 32'h5000_0040);
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0);
    chk("R6 zero report", fsr_o, 32'h5000_0040);
  endtask

  task automatic t_merge_inv();
    wipe();
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h0020_0000, 0, 0);
    chk("R8 zdz", fsr_o, 32'hA020_0000);
    chk("R7 disabled", 32'(trap_o), 0);
    cmd(OP_SETB, 24, 0, 0, 0, 0, 0, 0, 0, 0);
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h0000_0200, 0, 0);
    chk("R8 sqrt enabled", fsr_o, 32'hE020_0280);
    chk("R7 trap", 32'(trap_o), 1);
  endtask

  task automatic t_class();
    wipe();
    cmd(OP_MWR, 0, 0, 0, 0, 8'hFF, 32'h0001_F000, 0, 0, 0);
    cmd(OP_MERGE, 0, 0, 0, 0, 0, 0, 32'h0000_4000, 0, 0);
    chk("R9 class replace", fsr_o, 32'h0000_4000);
    wipe();
    cmd(OP_MERGE, 0, 0, 6, 0, 0, 0, 32'h0000_2000, 1, 1);
    chk("R10 cmp word", fsr_o, 32'h0000_2000);
    chk("R10 cmp field", 32'(cr_field_o), 32'h2);
    chk("R10 cmp idx", 32'(cr_idx_o), 6);
  endtask

  task automatic t_tocr();
    cmd(OP_MWR, 0, 0, 0, 0, 8'hFF, 32'hF000_00F0, 0, 0, 0);
    cmd(OP_TOCR, 0, 0, 3, 0, 0, 0, 0, 0, 0);
    chk("R12 field0 word", fsr_o, 32'h6000_00F0);
    chk("R12 field0 value", 32'(cr_field_o), 32'hF);
    chk("R12 field0 idx", 32'(cr_idx_o), 3);
    chk("R11 trap kept", 32'(trap_o), 1);
    cmd(OP_TOCR, 0, 6, 0, 0, 0, 0, 0, 0, 0);
    chk("R12 enables kept", fsr_o, 32'h6000_00F0);
    chk("R12 field6 value", 32'(cr_field_o), 32'hF);
    repeat (3) @(negedge clk);
    chk("R13 idle hold", fsr_o, 32'h6000_00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_bits();
    t_fimm();
    t_mwr();
    t_merge_en();
    t_merge_inv();
    t_class();
    t_tocr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule